// File: doc/BRIEF.md
# Clocked Serial Transmitter with FIFO

This block sends bytes from a small transmit queue out on a single serial data line, most significant bit first. It can also drive a companion clock pin. A receiver on the far end samples the data on the rising edge of that clock. Software fills the queue through a write port and then pulses a go input. From that point the block shifts bits out at a rate set by a divider of the system clock.

There are two ways to end a transfer:
- **Frame mode** stops after a programmed number of bits.
- **Continuous mode** ignores the bit count and keeps going until the queue runs dry.

The idle level of the clock pin is selectable. It can park low, park high, or keep toggling between transfers. The data line can lag each bit boundary by a small number of system cycles, to match the delay of the wire. A ready output shows when a new go will be accepted.

Top module: `sertx`

## Requirements
- R1: After reset, `ready`=1, `empty`=1, `full`=0, `ovf_err`=0 and `sdata`=0. In clock mode 2'b00, `sclk`=0.
- R2: The queue holds `FIFO_DEPTH` (default 4) bytes. `full` is 1 exactly when it holds that many, and `empty` is 1 exactly when it holds none.
- R3: A write while `full` is dropped, and that byte is never transmitted. The write sets `ovf_err`, which then stays 1 until reset.
- R4: Each byte is sent MSB first. A bit is placed on `sdata` at the start of its bit period, while `sclk` is low, and is held through the rising edge of `sclk`.
- R5: One bit period lasts `div`+1 system cycles, with `div` ≥ 1. During a transfer, `sclk` is low for the first (`div`+1)/2 cycles of each bit (integer division) and high for the rest.
- R6: A `go` is accepted only while `ready`=1 and `empty`=0; any other `go` has no effect. After an accepted `go`, `ready` is 0 for exactly N·(`div`+1) cycles, where N is the number of bits sent.
- R7: In frame mode (`cont_mode`=0), exactly `frame_bits`+1 bits are sent. The unsent low bits of a partly sent byte are discarded. Bytes not yet started stay queued.
- R8: In continuous mode (`cont_mode`=1), `frame_bits` is ignored and whole bytes are sent until the queue is empty.
- R9: In frame mode, if the queue empties at a byte boundary before the count is reached, the transfer ends at that boundary.
- R10: `clk_mode` sets the `sclk` level when no transfer is running: 2'b00 parks low, 2'b01 parks high, and 2'b10 or 2'b11 keep toggling with period `div`+1.
- R11: When `clk_pin_en`=0, `sclk` stays 0 at all times, and transfers still run with the same timing.
- R12: `sdata` changes exactly `wire_dly` system cycles after each bit boundary, for `wire_dly` from 0 to `WD_MAX`.
- R13: `sdata` is 0 whenever no bit is being sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Queue write strobe |
| wr_data | input | 8 | Byte to queue |
| go | input | 1 | Start a transfer |
| cont_mode | input | 1 | 1: drain the queue, 0: frame mode |
| frame_bits | input | FRM_W | Bits per frame minus one |
| div | input | DIV_W | Bit period minus one, in system cycles |
| clk_mode | input | 2 | Idle behaviour of the clock pin |
| clk_pin_en | input | 1 | Drive the generated clock onto `sclk` |
| wire_dly | input | WD_W | Data lag after a bit boundary, in cycles |
| full | output | 1 | Queue full |
| empty | output | 1 | Queue empty |
| ovf_err | output | 1 | Sticky write-while-full flag |
| ready | output | 1 | Block will accept `go` |
| sdata | output | 1 | Serial data |
| sclk | output | 1 | Serial clock |

## Verification
The assertions assume that `div`, `frame_bits`, `cont_mode`, `clk_mode` and `wire_dly` stay constant while `ready` is 0. They also assume `div` is at least 1. The stimulus changes these settings only between transfers, after `ready` has returned to 1.

Bit sampling on the rising edge of `sclk` is only valid when `wire_dly` is smaller than the low phase of a bit. Every test that checks data values keeps the divider large enough for that to hold.

// File: rtl/sertx_pkg.sv
package sertx_pkg;
   typedef enum logic [1:0] {
      CLK_PARK_LOW  = 2'b00,
      CLK_PARK_HIGH = 2'b01,
      CLK_FREE      = 2'b10,
      CLK_FREE_ALT  = 2'b11
   } clk_mode_e;
endpackage

// File: rtl/sertx_fifo.sv
module sertx_fifo #(
   parameter int W     = 8,
   parameter int DEPTH = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_en,
   input  logic [W-1:0] wr_data,
   input  logic         rd_en,
   output logic [W-1:0] rd_data,
   output logic         full,
   output logic         empty,
   output logic         ovf
);
   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CW = $clog2(DEPTH + 1);

   if (DEPTH < 2) begin : g_depth_chk
      $error("sertx_fifo: DEPTH must be at least 2");
   end

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wp, rp, wp_nx, rp_nx;
   logic [CW-1:0] cnt;
   logic          push, pop;

   assign full  = (cnt == CW'(DEPTH));
   assign empty = (cnt == '0);
   assign push  = wr_en && !full;
   assign pop   = rd_en && !empty;
   assign rd_data = mem[rp];

   // pointer wrap: free for power-of-two depths, compare otherwise
   if ((1 << AW) == DEPTH) begin : g_pow2
      assign wp_nx = wp + 1'b1;
      assign rp_nx = rp + 1'b1;
   end else begin : g_mod
      assign wp_nx = (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      assign rp_nx = (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp  <= '0;
         rp  <= '0;
         cnt <= '0;
         ovf <= 1'b0;
      end else begin
         if (push) wp <= wp_nx;
         if (pop)  rp <= rp_nx;
         if (push && !pop)      cnt <= cnt + 1'b1;
         else if (pop && !push) cnt <= cnt - 1'b1;
         if (wr_en && full) ovf <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (push) mem[wp] <= wr_data;
   end

   assert_flags_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !(full && empty));
   assert_ovf_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ovf |=> ovf);
   assert_ovf_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovf) |-> $past(wr_en && full));
endmodule

// File: rtl/sertx_wdelay.sv
module sertx_wdelay #(
   parameter int WD_MAX = 7,
   localparam int WD_W  = $clog2(WD_MAX + 1)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            d_in,
   input  logic [WD_W-1:0] sel,
   output logic            d_out
);
   if (WD_MAX < 1) begin : g_wd_chk
      $error("sertx_wdelay: WD_MAX must be at least 1");
   end

   logic [WD_MAX-1:0] line;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         line <= '0;
      end else begin
         line[0] <= d_in;
         for (int i = 1; i < WD_MAX; i++) line[i] <= line[i-1];
      end
   end

   assign d_out = (sel == '0) ? d_in : line[sel - 1'b1];
endmodule

// File: rtl/sertx_clkdrv.sv
module sertx_clkdrv
   import sertx_pkg::*;
(
   input  logic       busy,
   input  logic       phase_hi,
   input  logic [1:0] mode,
   input  logic       pin_en,
   output logic       sclk
);
   clk_mode_e m;
   logic      run;

   assign m   = clk_mode_e'(mode);
   assign run = busy || (m == CLK_FREE) || (m == CLK_FREE_ALT);

   always_comb begin
      if (!pin_en)  sclk = 1'b0;
      else if (run) sclk = phase_hi;
      else          sclk = (m == CLK_PARK_HIGH);
   end
endmodule

// File: rtl/sertx.sv
module sertx #(
   parameter int DIV_W      = 12,
   parameter int FIFO_DEPTH = 4,
   parameter int FRM_W      = 5,
   parameter int WD_MAX     = 7,
   localparam int WD_W      = $clog2(WD_MAX + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [7:0]       wr_data,
   input  logic             go,
   input  logic             cont_mode,
   input  logic [FRM_W-1:0] frame_bits,
   input  logic [DIV_W-1:0] div,
   input  logic [1:0]       clk_mode,
   input  logic             clk_pin_en,
   input  logic [WD_W-1:0]  wire_dly,
   output logic             full,
   output logic             empty,
   output logic             ovf_err,
   output logic             ready,
   output logic             sdata,
   output logic             sclk
);
   if (DIV_W < 1 || FRM_W < 1) begin : g_par_chk
      $error("sertx: DIV_W and FRM_W must be positive");
   end

   logic             busy;
   logic [DIV_W-1:0] cnt;
   logic [7:0]       sh;
   logic [2:0]       bidx;
   logic [FRM_W:0]   sc;
   logic [7:0]       fifo_q;
   logic [DIV_W:0]   half;
   logic             tick, start, byte_end, frame_end, pop, phase_hi, sdata_raw;

   assign tick      = (cnt >= div);
   assign start     = go && !busy && !empty;
   assign byte_end  = (bidx == 3'd7);
   assign frame_end = !cont_mode && (sc == {1'b0, frame_bits});
   assign pop       = start || (busy && tick && !frame_end && byte_end && !empty);
   assign half      = ({1'b0, div} + 1'b1) >> 1;
   assign phase_hi  = ({1'b0, cnt} >= half);
   assign sdata_raw = busy && sh[7];
   assign ready     = !busy;

   sertx_fifo #(.W(8), .DEPTH(FIFO_DEPTH)) u_fifo (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .rd_en(pop), .rd_data(fifo_q), .full(full), .empty(empty), .ovf(ovf_err)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0;
         cnt  <= '0;
         sh   <= '0;
         bidx <= '0;
         sc   <= '0;
      end else if (start) begin
         busy <= 1'b1;
         cnt  <= '0;
         sh   <= fifo_q;
         bidx <= '0;
         sc   <= '0;
      end else if (busy) begin
         if (tick) begin
            cnt <= '0;
            if (frame_end || (byte_end && empty)) begin
               busy <= 1'b0;
            end else if (byte_end) begin
               sh   <= fifo_q;
               bidx <= '0;
               sc   <= sc + 1'b1;
            end else begin
               sh   <= {sh[6:0], 1'b0};
               bidx <= bidx + 1'b1;
               sc   <= sc + 1'b1;
            end
         end else begin
            cnt <= cnt + 1'b1;
         end
      end else begin
         cnt <= tick ? '0 : cnt + 1'b1;
      end
   end

   sertx_wdelay #(.WD_MAX(WD_MAX)) u_wdelay (
      .clk(clk), .rst_n(rst_n), .d_in(sdata_raw), .sel(wire_dly), .d_out(sdata)
   );

   sertx_clkdrv u_clkdrv (
      .busy(busy), .phase_hi(phase_hi), .mode(clk_mode),
      .pin_en(clk_pin_en), .sclk(sclk)
   );

   assert_start_needs_go_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(go && !empty));
   assert_frame_len_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !cont_mode) |-> (sc <= {1'b0, frame_bits}));
   assert_bit_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !tick) |=> (cnt == $past(cnt) + 1'b1));
   assert_hold_bit_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !tick && !start) |=> $stable(sh));
endmodule

// File: tb/sertx_bench.sv
module sertx_bench;
   logic       clk = 0, rst_n = 0;
   logic       wr_en = 0, go = 0, cont_mode = 1, clk_pin_en = 1;
   logic [7:0] wr_data = 0;
   logic [4:0] frame_bits = 0;
   logic [11:0] div = 12'd3;
   logic [1:0] clk_mode = 2'b00;
   logic [2:0] wire_dly = 0;
   logic       full, empty, ovf_err, ready, sdata, sclk;

   sertx u_sertx (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .go(go),
      .cont_mode(cont_mode), .frame_bits(frame_bits), .div(div),
      .clk_mode(clk_mode), .clk_pin_en(clk_pin_en), .wire_dly(wire_dly),
      .full(full), .empty(empty), .ovf_err(ovf_err), .ready(ready),
      .sdata(sdata), .sclk(sclk)
   );

   always #5 clk = ~clk;

   int  n_chk = 0, n_err = 0;
   int  cyc = 0, lowcnt = 0, last_rise = 0, last_fall = 0, idle_rises = 0;
   bit  have_rise = 0, have_fall = 0, wd_chk = 0, sclk_hi_seen = 0;
   logic prev_sclk = 0, prev_sdata = 0;
   bit  exp_q[$];

   task automatic chk(input bit ok, input string req, input int got, input int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s got %0d exp %0d", req, got, exp);
      end
   endtask

   // monitor / scoreboard
   always @(negedge clk) begin
      cyc++;
      if (rst_n) begin
         if (!sclk && prev_sclk && !ready) begin
            last_fall = cyc;
            have_fall = 1;
         end
         if (sclk) sclk_hi_seen = 1;
         if (!ready) lowcnt++;
         if (ready && sclk && !prev_sclk) idle_rises++;
         if (sclk && !prev_sclk && !ready) begin
            if (exp_q.size() == 0) begin
               chk(0, "R4 unexpected bit", 1, 0);
            end else begin
               bit e;
               e = exp_q.pop_front();
               chk(sdata == e, "R4 bit value", sdata, e);
            end
            if (have_rise) chk(cyc - last_rise == int'(div) + 1, "R5 period",
                               cyc - last_rise, int'(div) + 1);
            if (have_fall) chk(cyc - last_fall == (int'(div) + 1) / 2, "R5 low phase",
                               cyc - last_fall, (int'(div) + 1) / 2);
            last_rise = cyc;
            have_rise = 1;
         end
         if (wd_chk && !ready && sdata != prev_sdata)
            chk(cyc - last_fall == int'(wire_dly), "R12 data lag",
                cyc - last_fall, int'(wire_dly));
         if (ready) begin
            have_rise = 0;
            have_fall = 0;
         end
      end
      prev_sclk  = sclk;
      prev_sdata = sdata;
   end

   // watchdog
   initial begin
      repeat (150000) @(posedge clk);
      chk(0, "watchdog", 0, 1);
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

   task automatic wr(input logic [7:0] b);
      @(posedge clk); #1;
      wr_en = 1; wr_data = b;
      @(posedge clk); #1;
      wr_en = 0;
   endtask

   task automatic expect_bits(input logic [7:0] b, input int n);
      for (int i = 7; i > 7 - n; i--) exp_q.push_back(b[i]);
   endtask

   task automatic pulse_go();
      @(posedge clk); #1;
      go = 1; lowcnt = 0; sclk_hi_seen = 0;
      @(posedge clk); #1;
      go = 0;
   endtask

   task automatic xfer(input int nbits, input string req);
      pulse_go();
      for (int i = 0; i < 20000; i++) begin
         @(negedge clk);
         if (ready) break;
      end
      #1;
      chk(ready == 1, "R6 transfer ends", ready, 1);
      chk(lowcnt == nbits * (int'(div) + 1), req, lowcnt, nbits * (int'(div) + 1));
      chk(exp_q.size() == 0, req, exp_q.size(), 0);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1;
      @(negedge clk);
      // R1 / R13 reset state
      chk(ready == 1 && empty == 1 && full == 0 && ovf_err == 0, "R1 flags",
          {ready, empty, full, ovf_err}, 4'b1100);
      chk(sdata == 0 && sclk == 0, "R1 R13 lines", {sdata, sclk}, 0);

      // continuous, park high, div 3
      clk_mode = 2'b01; div = 12'd3; cont_mode = 1;
      wr(8'hA3); wr(8'h5C);
      expect_bits(8'hA3, 8); expect_bits(8'h5C, 8);
      xfer(16, "R8 cont drain");
      repeat (6) @(negedge clk);
      chk(sclk == 1, "R10 park high", sclk, 1);
      chk(sdata == 0, "R13 idle data", sdata, 0);

      // queue limits and overflow, park low
      clk_mode = 2'b00;
      wr(8'h12); wr(8'h34); wr(8'h56);
      @(negedge clk);
      chk(full == 0 && empty == 0, "R2 three held", {full, empty}, 0);
      wr(8'h78);
      @(negedge clk);
      chk(full == 1, "R2 full at depth", full, 1);
      wr(8'h9A);
      @(negedge clk);
      chk(ovf_err == 1, "R3 overflow flag", ovf_err, 1);
      expect_bits(8'h12, 8); expect_bits(8'h34, 8);
      expect_bits(8'h56, 8); expect_bits(8'h78, 8);
      xfer(32, "R3 dropped byte not sent");
      chk(empty == 1 && full == 0, "R2 empty after drain", {full, empty}, 2'b01);
      chk(ovf_err == 1, "R3 sticky", ovf_err, 1);
      repeat (6) @(negedge clk);
      chk(sclk == 0, "R10 park low", sclk, 0);

      // frame mode, partial byte, div 1
      div = 12'd1; cont_mode = 0; frame_bits = 5'd11; clk_mode = 2'b01;
      wr(8'hF0); wr(8'h0F); wr(8'h81);
      expect_bits(8'hF0, 8); expect_bits(8'h0F, 4);
      xfer(12, "R7 frame length");
      chk(empty == 0, "R7 later byte kept", empty, 0);
      frame_bits = 5'd7;
      expect_bits(8'h81, 8);
      xfer(8, "R7 next frame whole byte");
      chk(empty == 1, "R7 queue drained", empty, 1);

      // frame longer than queue content
      div = 12'd3; frame_bits = 5'd31;
      wr(8'hC6);
      expect_bits(8'hC6, 8);
      xfer(8, "R9 underrun stop");

      // go while busy ignored, go while empty ignored
      frame_bits = 5'd7;
      wr(8'h11); wr(8'h22);
      expect_bits(8'h11, 8);
      fork
         xfer(8, "R6 busy go ignored");
         begin
            repeat (10) @(posedge clk);
            #1 go = 1;
            @(posedge clk); #1 go = 0;
         end
      join
      chk(empty == 0, "R6 second byte still queued", empty, 0);
      cont_mode = 1;
      expect_bits(8'h22, 8);
      xfer(8, "R8 drain leftover");
      pulse_go();
      repeat (3) @(negedge clk);
      chk(ready == 1 && lowcnt == 0, "R6 go on empty ignored", lowcnt, 0);

      // free-running clock
      clk_mode = 2'b10; div = 12'd5;
      wr(8'h3C);
      expect_bits(8'h3C, 8);
      xfer(8, "R10 free mode transfer");
      idle_rises = 0;
      repeat (30) @(negedge clk);
      chk(idle_rises >= 4, "R10 free toggles idle", idle_rises, 5);

      // wire delay
      clk_mode = 2'b01; div = 12'd5; wire_dly = 3'd2; wd_chk = 1;
      wr(8'hAA);
      expect_bits(8'hAA, 8);
      xfer(8, "R12 transfer with lag");
      wd_chk = 0; wire_dly = 0;

      // clock pin disabled
      clk_pin_en = 0; clk_mode = 2'b00; div = 12'd3;
      wr(8'h55);
      xfer(8, "R11 timing without pin");
      chk(sclk_hi_seen == 0, "R11 pin held low", sclk_hi_seen, 0);

      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end
endmodule